// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block keeps a 64-bit accumulator, seen as a high 32-bit word and a low 32-bit word. Each accepted operation multiplies two signed operands and adds the product into the accumulator. There are two kinds of operation. The long kind takes two signed 32-bit operands. The word kind takes the low 16 bits of each operand as signed values. A saturation input chooses, for each operation, between wrap-around arithmetic and saturating arithmetic. The two kinds saturate by different rules. The long kind clamps to a 48-bit signed range held inside the 64-bit accumulator. The saturating word kind works on the low word alone and marks an overflow by writing 1 into the high word.

Software or a sequencer loads each word directly, or clears both, through dedicated command inputs. Both words are driven out as registered outputs. The accumulator changes only on a clock edge, one cycle after the command or operation is presented.

Top module: `sat_mac_unit`

## Requirements
- R1: A synchronous active-low reset sets both accumulator words to zero.
- R2: With `op_sel` = 0 (long kind) and `sat_en` low, the signed 64-bit product of `op_a` and `op_b` is added to the full 64-bit accumulator, and the sum wraps modulo 2^64.
- R3: With `op_sel` = 0 and `sat_en` high, when the 64-bit sum does not overflow, the result is that sum clipped to the signed range -(2^47) to 2^47-1. Small sums such as -4 + (-1)(-2) = -2 pass through unchanged.
- R4: With `op_sel` = 0 and `sat_en` high, when the 64-bit addition overflows, the result is -(2^47) if the previous accumulator was negative and 2^47-1 otherwise.
- R5: With `op_sel` = 1 (word kind) and `sat_en` low, bits 15:0 of each operand are sign-extended, multiplied, and the product is added to the full 64-bit accumulator. Bits 31:16 of both operands have no effect.
- R6: With `op_sel` = 1 and `sat_en` high, the product is added to the low word as a signed 32-bit addition. When that addition does not overflow, the high word keeps its value.
- R7: With `op_sel` = 1 and `sat_en` high, a signed 32-bit overflow sets the low word to 0x80000000 if the old low word was negative, or to 0x7fffffff otherwise, and it writes 1 into the high word.
- R8: An operation strobed by `op_valid` appears on `acc_hi`/`acc_lo` after the next rising clock edge and not before. With no strobe and no command, both words hold their values.
- R9: Priority, highest first: `acc_clr` zeroes both words; then `hi_wr` and `lo_wr` load their own word independently; then an operation is accumulated. When a load or clear is present, a strobed operation in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Strobe: accumulate this cycle's operation |
| op_sel | input | 1 | Operation kind: 0 long (32x32), 1 word (16x16) |
| sat_en | input | 1 | 1 selects saturating arithmetic |
| op_a | input | 32 | First signed operand |
| op_b | input | 32 | Second signed operand |
| acc_clr | input | 1 | Clear both accumulator words |
| hi_wr | input | 1 | Load the high word from hi_wdata |
| hi_wdata | input | 32 | Data for a high-word load |
| lo_wr | input | 1 | Load the low word from lo_wdata |
| lo_wdata | input | 32 | Data for a low-word load |
| acc_hi | output | 32 | Accumulator bits 63:32 |
| acc_lo | output | 32 | Accumulator bits 31:0 |

## Verification
The bench aims at the boundaries where the two saturation rules differ. A long-kind 64-bit overflow must resolve by the sign of the previous accumulator; a design that clipped the wrapped sum would return the wrong bound. A sum that fits in 64 bits but lies outside 48 bits must be clipped; a design that tested only for 64-bit overflow would leave it unclipped. For the saturating word kind, the bench checks that a full-width add, or a clamp decided on the high word, gives a different result from the expected one. It checks that the high word is written with 1 only on overflow and is otherwise preserved, and that a borrow in the wrapping word kind carries into the high word. It also checks priority conflicts where an operation is strobed together with a clear or a load and must be dropped.

// File: rtl/satmac_pkg.sv
// Shared definitions for the saturating multiply-accumulate unit.
// Assumes: one operation-kind select bit at the top-level port.
package satmac_pkg;

    // Operation kind carried on op_sel
    typedef enum logic {
        KIND_LONG = 1'b0,
        KIND_WORD = 1'b1
    } mac_kind_e;

endpackage

// File: rtl/satmac_long.sv
// Long-kind datapath: signed MUL_W x MUL_W product added into an ACC_W
// accumulator, with optional clamp to a SAT_W-bit signed range.
// Assumes ACC_W >= 2*MUL_W and SAT_W <= ACC_W. Purely combinational.
module satmac_long #(
    parameter int MUL_W = 32,
    parameter int ACC_W = 64,
    parameter int SAT_W = 48
) (
    input  logic [ACC_W-1:0] acc_in,
    input  logic [MUL_W-1:0] mul_a,
    input  logic [MUL_W-1:0] mul_b,
    input  logic             sat,
    output logic [ACC_W-1:0] acc_out
);
    localparam int PROD_W = 2 * MUL_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;
    logic signed [ACC_W-1:0]  sum;
    logic                     add_ovf;
    logic [ACC_W-1:0]         clamped;

    // Full-precision product, sign-extended to the accumulator width
    always_comb begin
        prod     = $signed(mul_a) * $signed(mul_b);
        prod_ext = ACC_W'(prod);
    end

    // Wrapping sum and signed overflow of the full-width addition
    always_comb begin
        sum     = $signed(acc_in) + prod_ext;
        add_ovf = (acc_in[ACC_W-1] == prod_ext[ACC_W-1]) &&
                  (sum[ACC_W-1] != acc_in[ACC_W-1]);
    end

    generate
        if (SAT_W < ACC_W) begin : g_narrow_clamp
            localparam logic signed [ACC_W-1:0] SAT_MAX =
                (ACC_W'(1) << (SAT_W - 1)) - ACC_W'(1);
            localparam logic signed [ACC_W-1:0] SAT_MIN = ~SAT_MAX;

            // Overflow picks a bound by prior sign; otherwise clip the sum
            always_comb begin
                if (add_ovf)
                    clamped = acc_in[ACC_W-1] ? SAT_MIN : SAT_MAX;
                else if (sum > SAT_MAX)
                    clamped = SAT_MAX;
                else if (sum < SAT_MIN)
                    clamped = SAT_MIN;
                else
                    clamped = sum;
            end
        end else begin : g_full_clamp
            localparam logic signed [ACC_W-1:0] SAT_MAX = {1'b0, {(ACC_W-1){1'b1}}};
            localparam logic signed [ACC_W-1:0] SAT_MIN = ~SAT_MAX;

            // Full-width saturation needs only the overflow decision
            always_comb begin
                if (add_ovf)
                    clamped = acc_in[ACC_W-1] ? SAT_MIN : SAT_MAX;
                else
                    clamped = sum;
            end
        end
    endgenerate

    // Select wrapping or saturated result
    always_comb begin
        acc_out = sat ? clamped : sum;
    end

endmodule

// File: rtl/satmac_word.sv
// Word-kind datapath: signed HALF_W x HALF_W product. Wrapping mode adds
// it to the whole ACC_W accumulator; saturating mode adds it to the low
// LANE_W bits only and flags an overflow by writing 1 to the high part.
// Assumes 2*HALF_W <= LANE_W < ACC_W. Purely combinational.
module satmac_word #(
    parameter int HALF_W = 16,
    parameter int LANE_W = 32,
    parameter int ACC_W  = 64
) (
    input  logic [ACC_W-1:0]  acc_in,
    input  logic [LANE_W-1:0] mul_a,
    input  logic [LANE_W-1:0] mul_b,
    input  logic              sat,
    output logic [ACC_W-1:0]  acc_out
);
    localparam int HI_W = ACC_W - LANE_W;
    localparam logic signed [LANE_W-1:0] LANE_MAX = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic signed [LANE_W-1:0] LANE_MIN = ~LANE_MAX;

    logic signed [2*HALF_W-1:0] prod;
    logic signed [LANE_W-1:0]   prod_lane;
    logic signed [ACC_W-1:0]    prod_full;
    logic signed [LANE_W-1:0]   lo_old;
    logic signed [LANE_W-1:0]   lo_sum;
    logic                       lo_ovf;
    logic [ACC_W-1:0]           wrap_res;
    logic [ACC_W-1:0]           sat_res;
    logic                       unused_upper;

    assign unused_upper = ^{mul_a[LANE_W-1:HALF_W], mul_b[LANE_W-1:HALF_W]};

    // Product of the sign-extended low halves, widened twice
    always_comb begin
        prod      = $signed(mul_a[HALF_W-1:0]) * $signed(mul_b[HALF_W-1:0]);
        prod_lane = LANE_W'(prod);
        prod_full = ACC_W'(prod);
    end

    // Wrapping mode: full-width add
    always_comb begin
        wrap_res = acc_in + prod_full;
    end

    // Saturating mode: lane-only add; high part untouched unless overflow
    always_comb begin
        lo_old = $signed(acc_in[LANE_W-1:0]);
        lo_sum = lo_old + prod_lane;
        lo_ovf = (lo_old[LANE_W-1] == prod_lane[LANE_W-1]) &&
                 (lo_sum[LANE_W-1] != lo_old[LANE_W-1]);
        if (lo_ovf)
            sat_res = {HI_W'(1), (lo_old[LANE_W-1] ? LANE_MIN : LANE_MAX)};
        else
            sat_res = {acc_in[ACC_W-1:LANE_W], lo_sum};
    end

    // Select wrapping or saturated result
    always_comb begin
        acc_out = sat ? sat_res : wrap_res;
    end

endmodule

// File: rtl/sat_mac_unit.sv
// Top level of the saturating multiply-accumulate unit. Holds the
// accumulator register and applies commands by priority: clear, then
// word loads, then a strobed long- or word-kind operation.
// Assumes synchronous active-low reset; results appear one edge later.
module sat_mac_unit #(
    parameter int WORD_W = 32,
    parameter int HALF_W = 16,
    parameter int SAT_W  = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_sel,
    input  logic              sat_en,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              acc_clr,
    input  logic              hi_wr,
    input  logic [WORD_W-1:0] hi_wdata,
    input  logic              lo_wr,
    input  logic [WORD_W-1:0] lo_wdata,
    output logic [WORD_W-1:0] acc_hi,
    output logic [WORD_W-1:0] acc_lo
);
    import satmac_pkg::*;

    localparam int ACC_W = 2 * WORD_W;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] long_next;
    logic [ACC_W-1:0] word_next;
    logic [ACC_W-1:0] op_next;
    mac_kind_e        kind;

    satmac_long #(
        .MUL_W (WORD_W),
        .ACC_W (ACC_W),
        .SAT_W (SAT_W)
    ) u_long (
        .acc_in  (acc_q),
        .mul_a   (op_a),
        .mul_b   (op_b),
        .sat     (sat_en),
        .acc_out (long_next)
    );

    satmac_word #(
        .HALF_W (HALF_W),
        .LANE_W (WORD_W),
        .ACC_W  (ACC_W)
    ) u_word (
        .acc_in  (acc_q),
        .mul_a   (op_a),
        .mul_b   (op_b),
        .sat     (sat_en),
        .acc_out (word_next)
    );

    // Pick the datapath result for the requested kind
    always_comb begin
        kind    = mac_kind_e'(op_sel);
        op_next = (kind == KIND_WORD) ? word_next : long_next;
    end

    // Accumulator register with command priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (acc_clr) begin
            acc_q <= '0;
        end else if (hi_wr || lo_wr) begin
            if (hi_wr) acc_q[ACC_W-1:WORD_W] <= hi_wdata;
            if (lo_wr) acc_q[WORD_W-1:0]     <= lo_wdata;
        end else if (op_valid) begin
            acc_q <= op_next;
        end
    end

    assign acc_hi = acc_q[ACC_W-1:WORD_W];
    assign acc_lo = acc_q[WORD_W-1:0];

endmodule

// File: rtl/satmac_checks.sv
// Checker for sat_mac_unit: port-level temporal properties, bound below.
// Assumes the same parameters as the bound instance.
module satmac_checks #(
    parameter int WORD_W = 32,
    parameter int SAT_W  = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              op_sel,
    input logic              sat_en,
    input logic              acc_clr,
    input logic              hi_wr,
    input logic [WORD_W-1:0] hi_wdata,
    input logic              lo_wr,
    input logic [WORD_W-1:0] acc_hi,
    input logic [WORD_W-1:0] acc_lo
);
    localparam int TOP_BIT = SAT_W - 1 - WORD_W;

    logic no_cmd;
    assign no_cmd = !acc_clr && !hi_wr && !lo_wr;

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clr |=> (acc_hi == '0 && acc_lo == '0)); // R9

    AST_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_clr && hi_wr) |=> (acc_hi == $past(hi_wdata))); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (no_cmd && !op_valid) |=> ($stable(acc_hi) && $stable(acc_lo))); // R8

    AST_LONG_SAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (no_cmd && op_valid && !op_sel && sat_en)
        |=> ((&acc_hi[WORD_W-1:TOP_BIT]) || !(|acc_hi[WORD_W-1:TOP_BIT]))); // R3

    AST_WORD_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (no_cmd && op_valid && op_sel && sat_en)
        |=> (acc_hi == WORD_W'(1) || acc_hi == $past(acc_hi))); // R7

endmodule

bind sat_mac_unit satmac_checks #(
    .WORD_W (WORD_W),
    .SAT_W  (SAT_W)
) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_sel   (op_sel),
    .sat_en   (sat_en),
    .acc_clr  (acc_clr),
    .hi_wr    (hi_wr),
    .hi_wdata (hi_wdata),
    .lo_wr    (lo_wr),
    .acc_hi   (acc_hi),
    .acc_lo   (acc_lo)
);

// File: tb/sat_mac_unit_test.sv
module sat_mac_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;
    localparam int WATCHDOG = 5000;

    // {acc_init[64], a[32], b[32], op_sel, sat_en, expected[64]}
    localparam logic [193:0] VEC [NVEC] = '{
        {64'h0000000000000004, 32'h00000001, 32'h00000002, 1'b0, 1'b0, 64'h0000000000000006},
        {64'hfffffffffffffffc, 32'hffffffff, 32'hfffffffe, 1'b0, 1'b1, 64'hfffffffffffffffe},
        {64'h00007fff12345678, 32'h7fffffff, 32'h7fffffff, 1'b0, 1'b0, 64'h40007ffe12345679},
        {64'h00007fff12345678, 32'h7fffffff, 32'h7fffffff, 1'b0, 1'b1, 64'h00007fffffffffff},
        {64'h8000000000000000, 32'hffffffff, 32'h00000001, 1'b0, 1'b0, 64'h7fffffffffffffff},
        {64'h8000000000000000, 32'hffffffff, 32'h00000001, 1'b0, 1'b1, 64'hffff800000000000},
        {64'h7fffffffffffffff, 32'h00000001, 32'h00000001, 1'b0, 1'b1, 64'h00007fffffffffff},
        {64'hffff800000000000, 32'hffffffff, 32'h00000001, 1'b0, 1'b1, 64'hffff800000000000},
        {64'habcdef127ffffffa, 32'h00000002, 32'h00000003, 1'b1, 1'b0, 64'habcdef1280000000},
        {64'habcdef127ffffffa, 32'h00000002, 32'h00000003, 1'b1, 1'b1, 64'h000000017fffffff},
        {64'h123456787ffffffe, 32'h00000002, 32'hfffffffd, 1'b1, 1'b0, 64'h123456787ffffff8},
        {64'h123456787ffffffe, 32'h00000002, 32'hfffffffd, 1'b1, 1'b1, 64'h123456787ffffff8},
        {64'h0000000000000000, 32'hdead0002, 32'hbeef0003, 1'b1, 1'b0, 64'h0000000000000006},
        {64'h5555555580000000, 32'h00008000, 32'h00000001, 1'b1, 1'b1, 64'h0000000180000000},
        {64'h1234567800000010, 32'h0000ffff, 32'h00000010, 1'b1, 1'b1, 64'h1234567800000000},
        {64'h0000000500000000, 32'h0000ffff, 32'h00000001, 1'b1, 1'b0, 64'h00000004ffffffff}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_sel = 1'b0;
    logic        sat_en = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        acc_clr = 1'b0;
    logic        hi_wr = 1'b0;
    logic [31:0] hi_wdata = '0;
    logic        lo_wr = 1'b0;
    logic [31:0] lo_wdata = '0;
    logic [31:0] acc_hi;
    logic [31:0] acc_lo;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    sat_mac_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .sat_en(sat_en), .op_a(op_a), .op_b(op_b), .acc_clr(acc_clr),
        .hi_wr(hi_wr), .hi_wdata(hi_wdata), .lo_wr(lo_wr), .lo_wdata(lo_wdata),
        .acc_hi(acc_hi), .acc_lo(acc_lo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string vec_tag(int i);
        case (i)
            0, 2, 4:            return "R2";
            1, 3, 7:            return "R3";
            5, 6:               return "R4";
            8, 10, 12, 15:      return "R5";
            11, 14:             return "R6";
            default:            return "R7";
        endcase
    endfunction

    task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load_acc(logic [63:0] v);
        @(negedge clk);
        hi_wr = 1'b1; hi_wdata = v[63:32];
        lo_wr = 1'b1; lo_wdata = v[31:0];
        @(negedge clk);
        hi_wr = 1'b0; lo_wr = 1'b0;
    endtask

    task automatic idle();
        op_valid = 1'b0; acc_clr = 1'b0; hi_wr = 1'b0; lo_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check64("R1 reset", {acc_hi, acc_lo}, 64'h0);
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            load_acc(VEC[i][193:130]);
            op_a = VEC[i][129:98]; op_b = VEC[i][97:66];
            op_sel = VEC[i][65];  sat_en = VEC[i][64];
            op_valid = 1'b1;
            @(negedge clk);
            op_valid = 1'b0;
            check64(vec_tag(i), {acc_hi, acc_lo}, VEC[i][63:0]);
        end

        // R8: not visible before the edge, visible after it
        load_acc(64'h0000000000000004);
        op_a = 32'd1; op_b = 32'd2; op_sel = 1'b0; sat_en = 1'b0; op_valid = 1'b1;
        #(CLK_PERIOD/4);
        check64("R8 before edge", {acc_hi, acc_lo}, 64'h4);
        @(negedge clk);
        op_valid = 1'b0;
        check64("R8 after edge", {acc_hi, acc_lo}, 64'h6);
        // R8: operands change with no strobe -> hold
        op_a = 32'h12345678; op_b = 32'h7fffffff; sat_en = 1'b1;
        repeat (2) @(negedge clk);
        check64("R8 hold", {acc_hi, acc_lo}, 64'h6);

        // R9: clear beats a strobed operation
        acc_clr = 1'b1; op_valid = 1'b1; op_a = 32'd5; op_b = 32'd5;
        @(negedge clk);
        idle();
        check64("R9 clear over op", {acc_hi, acc_lo}, 64'h0);

        // R9: high load with strobe -> low word untouched, op dropped
        load_acc(64'h1111111122222222);
        hi_wr = 1'b1; hi_wdata = 32'hcafef00d; op_valid = 1'b1;
        op_sel = 1'b1; sat_en = 1'b0; op_a = 32'd3; op_b = 32'd3;
        @(negedge clk);
        idle();
        check64("R9 hi load over op", {acc_hi, acc_lo}, 64'hcafef00d22222222);

        // R9: low load only keeps high word
        lo_wr = 1'b1; lo_wdata = 32'h0badbeef;
        @(negedge clk);
        idle();
        check64("R9 lo load", {acc_hi, acc_lo}, 64'hcafef00d0badbeef);

        // R9: clear beats simultaneous loads
        acc_clr = 1'b1; hi_wr = 1'b1; lo_wr = 1'b1;
        hi_wdata = 32'hffffffff; lo_wdata = 32'hffffffff;
        @(negedge clk);
        idle();
        check64("R9 clear over load", {acc_hi, acc_lo}, 64'h0);

        // R5: upper operand bits ignored, two accumulations in a row
        op_sel = 1'b1; sat_en = 1'b0; op_a = 32'hffff0007; op_b = 32'h1234fffe;
        op_valid = 1'b1;
        repeat (2) @(negedge clk);
        op_valid = 1'b0;
        check64("R5 back-to-back", {acc_hi, acc_lo}, 64'hffffffffffffffe4);

        // R1: reset in mid-run clears a loaded value
        load_acc(64'h0123456789abcdef);
        rst_n = 1'b0; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        check64("R1 reset mid-run", {acc_hi, acc_lo}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule